// File: doc/BRIEF.md
# Inherent-Mode Accumulator Operation Unit

This unit carries out the register-only, single-byte data operations of a small 8-bit accumulator machine. It owns three pieces of architectural state: an accumulator (`acc_q`), an index-low register (`idx_q`) and a six-bit condition-code register (`ccr_q`). Each cycle it can take one opcode over a valid/ready handshake. The opcode is decoded and executed in the same cycle, and the new register values show on the outputs one clock later. A `done_q` pulse marks that cycle, together with the bus-cycle count the instruction costs.

The supported operations are shift left, logical shift right, rotate left through carry, and two's-complement negate, each on either register. Nibble swap acts on the accumulator only. There is also an unsigned 8x8 multiply whose 16-bit product fills the index:accumulator pair, and a no-op. Any other opcode is reported as illegal and changes no state.

Results of memory loads and stack pulls come from outside this unit. They enter through a write-back port that loads all three registers at once. While that port is active it takes priority, and the handshake refuses opcodes.

Top module: `inh_acc_unit`

## Requirements
- R1: Opcode 0x48 (accumulator) and 0x58 (index) shift the register left by one. A zero enters bit 0 and the old bit 7 goes to C.
- R2: Opcode 0x44 (accumulator) and 0x54 (index) shift the register right by one. A zero enters bit 7, the old bit 0 goes to C, and N is forced to 0.
- R3: Opcode 0x49 (accumulator) and 0x59 (index) rotate the register left through carry. The old C enters bit 0 and the old bit 7 becomes C.
- R4: Opcode 0x40 (accumulator) and 0x50 (index) replace the register with 0x00 minus its value. V is set only for an operand of 0x80. C is set exactly when the result is nonzero.
- R5: After a shift, rotate or negate, Z is set when the 8-bit result is zero and N equals result bit 7 (except under R2). For shifts and rotates, V equals N XOR C.
- R6: Opcode 0x62 exchanges the two nibbles of the accumulator. No flag and not the index register changes.
- R7: Opcode 0x42 multiplies index by accumulator unsigned. The high product byte goes to the index register and the low byte to the accumulator. H and C are cleared, V, N and Z keep their values, and the reported cycle count is 5.
- R8: Opcode 0x9D changes nothing and reports 1 cycle. Every legal opcode other than 0x42 also reports 1 cycle.
- R9: Any other opcode sets `illegal_q`, reports 0 cycles and leaves all three registers unchanged.
- R10: The CCR layout is bit 5 V, bit 4 H, bit 3 I, bit 2 N, bit 1 Z, bit 0 C. No opcode alters I, and only 0x42 alters H.
- R11: Reset clears all registers and `done_q`. An opcode accepted at one edge shows its results, `done_q` and `cycles_q` right after the next edge. `done_q` stays low when nothing was accepted.
- R12: With `wb_en` high, the three registers load from the write-back inputs, `op_ready` is low, and an offered opcode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode offered |
| op_ready | output | 1 | Unit can accept an opcode this cycle |
| opcode | input | 8 | One-byte inherent opcode |
| wb_en | input | 1 | Load registers from write-back inputs |
| wb_acc | input | 8 | Write-back accumulator value |
| wb_idx | input | 8 | Write-back index value |
| wb_ccr | input | 6 | Write-back CCR value (R10 layout) |
| acc_q | output | 8 | Accumulator |
| idx_q | output | 8 | Index-low register |
| ccr_q | output | 6 | Condition codes (R10 layout) |
| done_q | output | 1 | One-cycle pulse after an accepted opcode |
| illegal_q | output | 1 | Accepted opcode was unrecognised; valid with `done_q` |
| cycles_q | output | 4 | Bus cycles of the accepted opcode; valid with `done_q` |

## Verification
The bench loads operands through the write-back port and steers them at the flag corners. It negates 0x80 and zero: a design with a wrong V or C rule would flag overflow for zero or miss the carry on 0x80. It runs shift-right with N preset to catch a design that copies bit 7 into N. It chains a rotate into a second rotate so that a stale carry would corrupt bit 0. It runs multiply with all flags set to catch H or C that is not cleared or V/N/Z that is disturbed, and a 0xFF by 0xFF product exposes a truncated high byte. Finally it tries illegal opcodes, back-to-back issue, and a write-back that collides with an offered opcode: a leaky decoder or a broken priority would then alter state or pulse `done_q`.

// File: rtl/iau_pkg.sv
package iau_pkg;
    localparam int DW      = 8;
    localparam int CYC_W   = 4;
    localparam int MUL_CYC = 5;
    localparam int NOPND   = 2;   // operand registers: 0 = acc, 1 = idx

    typedef enum logic [2:0] {
        K_NOP, K_ASL, K_LSR, K_ROL, K_NEG, K_NSA, K_MUL, K_BAD
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  on_idx;
    } dec_t;

    typedef struct packed {
        logic v;
        logic h;
        logic i;
        logic n;
        logic z;
        logic c;
    } flags_t;

    function automatic logic is_unary(kind_e k);
        return (k == K_ASL) || (k == K_LSR) || (k == K_ROL) || (k == K_NEG);
    endfunction
endpackage

// File: rtl/iau_decode.sv
module iau_decode
    import iau_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    always_comb begin
        dec.on_idx = 1'b0;
        unique case (opcode)
            8'h48: dec.kind = K_ASL;
            8'h58: begin dec.kind = K_ASL; dec.on_idx = 1'b1; end
            8'h44: dec.kind = K_LSR;
            8'h54: begin dec.kind = K_LSR; dec.on_idx = 1'b1; end
            8'h49: dec.kind = K_ROL;
            8'h59: begin dec.kind = K_ROL; dec.on_idx = 1'b1; end
            8'h40: dec.kind = K_NEG;
            8'h50: begin dec.kind = K_NEG; dec.on_idx = 1'b1; end
            8'h62: dec.kind = K_NSA;
            8'h42: dec.kind = K_MUL;
            8'h9D: dec.kind = K_NOP;
            default: dec.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/iau_unary.sv
module iau_unary
    import iau_pkg::*;
#(
    parameter int W = 8
) (
    input  kind_e          kind,
    input  logic [W-1:0]   d,
    input  logic           cin,
    output logic [W-1:0]   r,
    output logic           cout
);
    always_comb begin
        r    = d;
        cout = cin;
        case (kind)
            K_ASL: begin r = {d[W-2:0], 1'b0}; cout = d[W-1]; end
            K_LSR: begin r = {1'b0, d[W-1:1]}; cout = d[0];   end
            K_ROL: begin r = {d[W-2:0], cin};  cout = d[W-1]; end
            K_NEG: begin r = '0 - d;           cout = |d;     end
            default: ;
        endcase
    end
endmodule

// File: rtl/iau_exec.sv
module iau_exec
    import iau_pkg::*;
(
    input  dec_t              dec,
    input  logic [DW-1:0]     acc,
    input  logic [DW-1:0]     idx,
    input  flags_t            fl,
    output logic [DW-1:0]     acc_n,
    output logic [DW-1:0]     idx_n,
    output flags_t            fl_n,
    output logic [CYC_W-1:0]  cycles,
    output logic              illegal
);
    localparam logic [DW-1:0] MSB_ONLY = {1'b1, {(DW-1){1'b0}}};
    localparam int HALF = DW / 2;

    logic [DW-1:0] opnd [NOPND];
    logic [DW-1:0] ures [NOPND];
    logic          ucar [NOPND];

    assign opnd[0] = acc;
    assign opnd[1] = idx;

    for (genvar g = 0; g < NOPND; g++) begin : g_unary
        iau_unary #(.W(DW)) u_unary (
            .kind (dec.kind),
            .d    (opnd[g]),
            .cin  (fl.c),
            .r    (ures[g]),
            .cout (ucar[g])
        );
    end

    logic [2*DW-1:0] prod;
    logic [DW-1:0]   res, src;
    logic            rc;

    always_comb begin
        prod    = idx * acc;
        res     = dec.on_idx ? ures[1] : ures[0];
        src     = dec.on_idx ? idx : acc;
        rc      = dec.on_idx ? ucar[1] : ucar[0];
        acc_n   = acc;
        idx_n   = idx;
        fl_n    = fl;
        cycles  = CYC_W'(1);
        illegal = 1'b0;
        if (is_unary(dec.kind)) begin
            if (dec.on_idx) idx_n = res;
            else            acc_n = res;
            fl_n.c = rc;
            fl_n.z = (res == '0);
            fl_n.n = (dec.kind == K_LSR) ? 1'b0 : res[DW-1];
            fl_n.v = (dec.kind == K_NEG) ? (src == MSB_ONLY) : (fl_n.n ^ rc);
        end else begin
            case (dec.kind)
                K_NSA: acc_n = {acc[HALF-1:0], acc[DW-1:HALF]};
                K_MUL: begin
                    idx_n  = prod[2*DW-1:DW];
                    acc_n  = prod[DW-1:0];
                    fl_n.h = 1'b0;
                    fl_n.c = 1'b0;
                    cycles = CYC_W'(MUL_CYC);
                end
                K_BAD: begin
                    cycles  = '0;
                    illegal = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/inh_acc_unit.sv
module inh_acc_unit
    import iau_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [7:0]        opcode,
    input  logic              wb_en,
    input  logic [DW-1:0]     wb_acc,
    input  logic [DW-1:0]     wb_idx,
    input  logic [5:0]        wb_ccr,
    output logic [DW-1:0]     acc_q,
    output logic [DW-1:0]     idx_q,
    output logic [5:0]        ccr_q,
    output logic              done_q,
    output logic              illegal_q,
    output logic [CYC_W-1:0]  cycles_q
);
    dec_t             dec;
    flags_t           fl_q, fl_n;
    logic [DW-1:0]    acc_n, idx_n;
    logic [CYC_W-1:0] cyc_n;
    logic             ill_n;
    logic             accept;

    assign op_ready = !rst && !wb_en;
    assign accept   = op_valid && op_ready;
    assign ccr_q    = fl_q;

    iau_decode u_decode (.opcode(opcode), .dec(dec));

    iau_exec u_exec (
        .dec     (dec),
        .acc     (acc_q),
        .idx     (idx_q),
        .fl      (fl_q),
        .acc_n   (acc_n),
        .idx_n   (idx_n),
        .fl_n    (fl_n),
        .cycles  (cyc_n),
        .illegal (ill_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            idx_q     <= '0;
            fl_q      <= '0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            cycles_q  <= '0;
        end else begin
            done_q <= accept;
            if (wb_en) begin
                acc_q <= wb_acc;
                idx_q <= wb_idx;
                fl_q  <= flags_t'(wb_ccr);
            end else if (accept) begin
                acc_q     <= acc_n;
                idx_q     <= idx_n;
                fl_q      <= fl_n;
                illegal_q <= ill_n;
                cycles_q  <= cyc_n;
            end
        end
    end

    // R11: done follows an accepted opcode by one cycle
    p_done_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
        accept |=> done_q);
    p_no_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !done_q);

    // R9: an illegal opcode leaves the registers as they were
    p_illegal_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (done_q && illegal_q) |-> (acc_q == $past(acc_q) && idx_q == $past(idx_q)
                                   && fl_q == $past(fl_q)));

    // R10: I never moves under an opcode; H moves only under multiply
    p_ibit_kept_r10: assert property (@(posedge clk) disable iff (rst)
        done_q |-> fl_q.i == $past(fl_q.i));
    p_hbit_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (done_q && $past(dec.kind) != K_MUL) |-> fl_q.h == $past(fl_q.h));

    // R7: multiply clears H and C and reports its longer cycle count
    p_mul_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (done_q && $past(dec.kind) == K_MUL)
            |-> (!fl_q.h && !fl_q.c && cycles_q == CYC_W'(MUL_CYC)));

    // R2: logical shift right always leaves N clear
    p_lsr_n_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (done_q && $past(dec.kind) == K_LSR) |-> !fl_q.n);

    // R6: nibble swap leaves flags and index unchanged
    p_nsa_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (done_q && $past(dec.kind) == K_NSA)
            |-> (fl_q == $past(fl_q) && idx_q == $past(idx_q)));
endmodule

// File: tb/inh_acc_unit_bench.sv
module inh_acc_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic       op_ready;
    logic [7:0] opcode = 8'h00;
    logic       wb_en = 1'b0;
    logic [7:0] wb_acc = 8'h00, wb_idx = 8'h00;
    logic [5:0] wb_ccr = 6'h00;
    logic [7:0] acc_q, idx_q;
    logic [5:0] ccr_q;
    logic       done_q, illegal_q;
    logic [3:0] cycles_q;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inh_acc_unit u_inh_acc_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .opcode(opcode), .wb_en(wb_en), .wb_acc(wb_acc), .wb_idx(wb_idx),
        .wb_ccr(wb_ccr), .acc_q(acc_q), .idx_q(idx_q), .ccr_q(ccr_q),
        .done_q(done_q), .illegal_q(illegal_q), .cycles_q(cycles_q)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] a, input logic [7:0] x, input logic [5:0] f);
        @(negedge clk);
        wb_en = 1'b1; wb_acc = a; wb_idx = x; wb_ccr = f;
        @(negedge clk);
        wb_en = 1'b0;
    endtask

    // issue one opcode, then check every output one cycle later
    task automatic run_op(input string tag, input logic [7:0] op,
                          input logic [7:0] ea, input logic [7:0] ex,
                          input logic [5:0] ef, input logic [3:0] ecyc,
                          input logic eill);
        @(negedge clk);
        op_valid = 1'b1; opcode = op;
        @(negedge clk);
        op_valid = 1'b0;
        chk({tag, " done"}, 16'(done_q), 16'h1);
        chk({tag, " acc"}, 16'(acc_q), 16'(ea));
        chk({tag, " idx"}, 16'(idx_q), 16'(ex));
        chk({tag, " ccr"}, 16'(ccr_q), 16'(ef));
        chk({tag, " cycles"}, 16'(cycles_q), 16'(ecyc));
        chk({tag, " illegal"}, 16'(illegal_q), 16'(eill));
    endtask

    task automatic t_reset;
        chk("R11 reset acc", 16'(acc_q), 16'h0);
        chk("R11 reset idx", 16'(idx_q), 16'h0);
        chk("R11 reset ccr", 16'(ccr_q), 16'h0);
        chk("R11 reset done", 16'(done_q), 16'h0);
        chk("R11 ready after reset", 16'(op_ready), 16'h1);
    endtask

    task automatic t_asl;   // R1 R5
        preload(8'hC1, 8'h80, 6'h00);
        run_op("R1 asl acc", 8'h48, 8'h82, 8'h80, 6'h05, 4'd1, 1'b0);
        run_op("R1 R5 asl idx zero", 8'h58, 8'h82, 8'h00, 6'h23, 4'd1, 1'b0);
    endtask

    task automatic t_lsr;   // R2 with N preset
        preload(8'h81, 8'h01, 6'h04);
        run_op("R2 lsr acc", 8'h44, 8'h40, 8'h01, 6'h21, 4'd1, 1'b0);
        run_op("R2 lsr idx zero", 8'h54, 8'h40, 8'h00, 6'h23, 4'd1, 1'b0);
    endtask

    task automatic t_rol;   // R3: carry chains between rotates
        preload(8'h80, 8'h40, 6'h01);
        run_op("R3 rol acc", 8'h49, 8'h01, 8'h40, 6'h21, 4'd1, 1'b0);
        run_op("R3 rol idx", 8'h59, 8'h01, 8'h81, 6'h24, 4'd1, 1'b0);
    endtask

    task automatic t_neg;   // R4 corners
        preload(8'h80, 8'h00, 6'h00);
        run_op("R4 neg 0x80", 8'h40, 8'h80, 8'h00, 6'h25, 4'd1, 1'b0);
        run_op("R4 neg zero idx", 8'h50, 8'h80, 8'h00, 6'h02, 4'd1, 1'b0);
        preload(8'h01, 8'h00, 6'h00);
        run_op("R4 R5 neg 1", 8'h40, 8'hFF, 8'h00, 6'h05, 4'd1, 1'b0);
    endtask

    task automatic t_hi_keep;   // R10: H and I survive a shift
        preload(8'h01, 8'h00, 6'h18);
        run_op("R10 asl keeps H I", 8'h48, 8'h02, 8'h00, 6'h18, 4'd1, 1'b0);
    endtask

    task automatic t_nsa;
        preload(8'h3C, 8'h11, 6'h3F);
        run_op("R6 nsa", 8'h62, 8'hC3, 8'h11, 6'h3F, 4'd1, 1'b0);
    endtask

    task automatic t_mul;
        preload(8'h34, 8'h12, 6'h3F);
        run_op("R7 mul flags", 8'h42, 8'hA8, 8'h03, 6'h2E, 4'd5, 1'b0);
        preload(8'hFF, 8'hFF, 6'h00);
        run_op("R7 mul max", 8'h42, 8'h01, 8'hFE, 6'h00, 4'd5, 1'b0);
    endtask

    task automatic t_nop;
        preload(8'h5A, 8'hA5, 6'h15);
        run_op("R8 nop", 8'h9D, 8'h5A, 8'hA5, 6'h15, 4'd1, 1'b0);
    endtask

    task automatic t_illegal;
        preload(8'h5A, 8'hA5, 6'h2B);
        run_op("R9 illegal 41", 8'h41, 8'h5A, 8'hA5, 6'h2B, 4'd0, 1'b1);
        run_op("R9 illegal 00", 8'h00, 8'h5A, 8'hA5, 6'h2B, 4'd0, 1'b1);
        run_op("R9 illegal FF", 8'hFF, 8'h5A, 8'hA5, 6'h2B, 4'd0, 1'b1);
    endtask

    task automatic t_back_to_back;   // R11
        preload(8'h01, 8'h00, 6'h00);
        @(negedge clk);
        op_valid = 1'b1; opcode = 8'h48;
        @(negedge clk);
        chk("R11 b2b first acc", 16'(acc_q), 16'h02);
        chk("R11 b2b first done", 16'(done_q), 16'h1);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R11 b2b second acc", 16'(acc_q), 16'h04);
        chk("R11 b2b second done", 16'(done_q), 16'h1);
        @(negedge clk);
        chk("R11 done drops", 16'(done_q), 16'h0);
    endtask

    task automatic t_wb_priority;   // R12
        @(negedge clk);
        wb_en = 1'b1; wb_acc = 8'h07; wb_idx = 8'h00; wb_ccr = 6'h00;
        op_valid = 1'b1; opcode = 8'h48;
        #1;
        chk("R12 ready low", 16'(op_ready), 16'h0);
        @(negedge clk);
        wb_en = 1'b0; op_valid = 1'b0;
        chk("R12 wb acc", 16'(acc_q), 16'h07);
        chk("R12 op ignored", 16'(done_q), 16'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_asl();
        t_lsr();
        t_rol();
        t_neg();
        t_hi_keep();
        t_nsa();
        t_mul();
        t_nop();
        t_illegal();
        t_back_to_back();
        t_wb_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule